// File: doc/BRIEF.md
# Prioritized 256-Vector Interrupt Tracker

This block keeps the bookkeeping for 256 interrupt vectors in one core. It holds three 256-bit arrays: a request array for vectors that wait to be handed out, an in-service array for vectors that have been taken and not yet retired, and an enable array that gates new requests. A raise strobe carrying a vector number marks that vector as requested when its enable bit is set. The block reports whether a vector should be handed out, and which one. An acknowledge strobe moves a requested vector into service. An end-of-interrupt strobe retires the highest vector that is in service.

Priority rises with the vector number. Two 256-bit priority encoders find the highest request and the highest in-service vector. A vector is offered only when the top request is strictly above the top in-service vector, so a handler is never pre-empted by an equal or lower vector. A 32-bit register port shows each array as eight words. Only the enable words can be written. The pending flag and the offered vector are registered. They follow any change of the arrays one clock later.

Top module: `intr_vector_tracker`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), every request and in-service bit reads 0, every enable bit reads 1, and pend_o and pend_vec_o are 0.
- R2: A raise of vector N whose enable bit is 1 sets request bit N. Vector N appears in word N>>5, bit N&31 of its array.
- R3: A raise of a vector whose enable bit is 0 is dropped and leaves the request array unchanged.
- R4: A raise of a vector that is already requested merges into the existing request and keeps no count. A single acknowledge empties it.
- R5: pend_o is 1 only when some request bit is set and the highest request vector is strictly greater than the highest in-service vector. An empty in-service array counts as level -1. An equal or lower request gives pend_o = 0.
- R6: pend_vec_o carries the highest requested vector number, or 0 when nothing is requested. pend_o and pend_vec_o are registered and reflect the arrays as they stood one clock earlier.
- R7: Acknowledge of vector V sets in-service bit V and clears request bit V if request bit V was set. If request bit V was clear, nothing changes.
- R8: End-of-interrupt clears only the highest set in-service bit. With no bit in service it has no effect.
- R9: Register map (12-bit byte address, word stride 0x10, word k at base + 0x10*k, lowest vectors in word 0): in-service reads at 0x100..0x170, request reads at 0x200..0x270, enable reads and writes at 0x480..0x4F0. Writes to any other address are ignored. Unmapped reads return 0.
- R10: When a raise and an acknowledge name the same requested, enabled vector in the same cycle, the acknowledge takes effect first. The vector ends up both in service and requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| raise_vld | input | 1 | Raise strobe for raise_vec |
| raise_vec | input | 8 | Vector number to raise |
| ack_vld | input | 1 | Acknowledge strobe for ack_vec |
| ack_vec | input | 8 | Vector number being acknowledged |
| eoi | input | 1 | End-of-interrupt strobe |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| pend_o | output | 1 | A vector is ready to be handed out (registered) |
| pend_vec_o | output | 8 | Highest requested vector (registered) |

## Verification
The assertions assume that each strobe is a single-cycle pulse and that its vector number is stable while the strobe is high. The eoi property also assumes that an eoi does not arrive in the same cycle as an acknowledge, so that the in-service count can only fall by one. The bench drives every input one time unit after a rising edge and holds it for exactly one cycle. It issues end-of-interrupt alone in every case, and the same-cycle raise and acknowledge case uses one shared vector number, as R10 describes.

// File: rtl/ivt_pkg.sv
// Package ivt_pkg
// Shared types for the interrupt vector tracker: the register region
// decoded from a bus address. Assumes nothing beyond SystemVerilog 2017.
package ivt_pkg;

    typedef enum logic [1:0] {
        REGION_NONE = 2'd0,
        REGION_SVC  = 2'd1,
        REGION_REQ  = 2'd2,
        REGION_EN   = 2'd3
    } region_e;

endpackage

// File: rtl/ivt_prio_enc.sv
// Module ivt_prio_enc
// Combinational highest-set-bit encoder. The highest index wins.
// found is 0 and idx is 0 when no bit is set.
// Assumes WIDTH <= 2**IDX_W.
module ivt_prio_enc #(
    parameter int WIDTH = 256,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan upward so that the last (highest) set bit is the one kept
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ivt_vec_state.sv
// Module ivt_vec_state
// Holds the request, in-service and enable arrays and applies the raise,
// acknowledge, end-of-interrupt and enable-word write events.
// Event order within one cycle: eoi clears the current top in-service bit,
// then the acknowledge moves a requested vector into service, then the
// raise sets a request when it is enabled.
// Assumes the top in-service index is supplied from isr_q by the parent.
module ivt_vec_state #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    parameter int VEC_W   = $clog2(NUM_VEC),
    parameter int NUM_WRD = NUM_VEC / WORD_W,
    parameter int WSEL_W  = (NUM_WRD > 1) ? $clog2(NUM_WRD) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raise_vld,
    input  logic [VEC_W-1:0]   raise_vec,
    input  logic               ack_vld,
    input  logic [VEC_W-1:0]   ack_vec,
    input  logic               eoi,
    input  logic               svc_top_vld,
    input  logic [VEC_W-1:0]   svc_top_idx,
    input  logic               en_we,
    input  logic [WSEL_W-1:0]  en_wsel,
    input  logic [WORD_W-1:0]  en_wdata,
    output logic [NUM_VEC-1:0] req_q,
    output logic [NUM_VEC-1:0] svc_q,
    output logic [NUM_VEC-1:0] en_q
);

    logic [NUM_VEC-1:0] req_d;
    logic [NUM_VEC-1:0] svc_d;
    logic               ack_hit;

    assign ack_hit = ack_vld && req_q[ack_vec];

    // Next-state of the request and in-service arrays from this cycle's events
    always_comb begin
        req_d = req_q;
        svc_d = svc_q;
        if (eoi && svc_top_vld) begin
            svc_d[svc_top_idx] = 1'b0;
        end
        if (ack_hit) begin
            req_d[ack_vec] = 1'b0;
            svc_d[ack_vec] = 1'b1;
        end
        if (raise_vld && en_q[raise_vec]) begin
            req_d[raise_vec] = 1'b1;
        end
    end

    // Request and in-service registers, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            svc_q <= '0;
        end else begin
            req_q <= req_d;
            svc_q <= svc_d;
        end
    end

    // One register slice per enable word, set to all ones by reset
    for (genvar w = 0; w < NUM_WRD; w++) begin : g_en_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[w*WORD_W +: WORD_W] <= '1;
            end else if (en_we && (en_wsel == WSEL_W'(w))) begin
                en_q[w*WORD_W +: WORD_W] <= en_wdata;
            end
        end
    end

endmodule

// File: rtl/ivt_reg_if.sv
// Module ivt_reg_if
// Decodes the 32-bit register port. Each array is shown as NUM_WRD words
// at base + STRIDE*k. Only the enable words accept writes. Reads are
// combinational and unmapped addresses read 0.
// Assumes STRIDE is a power of two and every base is STRIDE aligned.
module ivt_reg_if #(
    parameter int          NUM_VEC  = 256,
    parameter int          WORD_W   = 32,
    parameter int          ADDR_W   = 12,
    parameter int          STRIDE   = 16,
    parameter logic [11:0] SVC_BASE = 12'h100,
    parameter logic [11:0] REQ_BASE = 12'h200,
    parameter logic [11:0] EN_BASE  = 12'h480,
    parameter int          NUM_WRD  = NUM_VEC / WORD_W,
    parameter int          WSEL_W   = (NUM_WRD > 1) ? $clog2(NUM_WRD) : 1
) (
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [WORD_W-1:0]  reg_wdata,
    input  logic [NUM_VEC-1:0] req_q,
    input  logic [NUM_VEC-1:0] svc_q,
    input  logic [NUM_VEC-1:0] en_q,
    output logic               en_we,
    output logic [WSEL_W-1:0]  en_wsel,
    output logic [WORD_W-1:0]  en_wdata,
    output logic [WORD_W-1:0]  reg_rdata
);
    import ivt_pkg::*;

    localparam int          STRIDE_SH = $clog2(STRIDE);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WRD * STRIDE);

    region_e           region;
    logic [ADDR_W-1:0] rel;

    // Region and relative offset of the current address
    always_comb begin
        region = REGION_NONE;
        rel    = '0;
        if (reg_addr[STRIDE_SH-1:0] == '0) begin
            if (reg_addr >= ADDR_W'(SVC_BASE) && reg_addr < ADDR_W'(SVC_BASE) + SPAN) begin
                region = REGION_SVC;
                rel    = reg_addr - ADDR_W'(SVC_BASE);
            end else if (reg_addr >= ADDR_W'(REQ_BASE) && reg_addr < ADDR_W'(REQ_BASE) + SPAN) begin
                region = REGION_REQ;
                rel    = reg_addr - ADDR_W'(REQ_BASE);
            end else if (reg_addr >= ADDR_W'(EN_BASE) && reg_addr < ADDR_W'(EN_BASE) + SPAN) begin
                region = REGION_EN;
                rel    = reg_addr - ADDR_W'(EN_BASE);
            end
        end
    end

    logic [ADDR_W-1:0] word_full;
    assign word_full = rel >> STRIDE_SH;
    assign en_wsel   = word_full[WSEL_W-1:0];
    assign en_we     = reg_we && (region == REGION_EN);
    assign en_wdata  = reg_wdata;

    // Read data multiplexer
    always_comb begin
        case (region)
            REGION_SVC: reg_rdata = svc_q[en_wsel*WORD_W +: WORD_W];
            REGION_REQ: reg_rdata = req_q[en_wsel*WORD_W +: WORD_W];
            REGION_EN:  reg_rdata = en_q[en_wsel*WORD_W +: WORD_W];
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/intr_vector_tracker.sv
// Module intr_vector_tracker
// Top level of the prioritized vector tracker. It holds the arrays, finds
// the top request and the top in-service vector, and registers the
// pending decision and the offered vector.
// Assumes single-cycle strobes from a synchronous source.
module intr_vector_tracker #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 12,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_vld,
    input  logic [VEC_W-1:0]  raise_vec,
    input  logic              ack_vld,
    input  logic [VEC_W-1:0]  ack_vec,
    input  logic              eoi,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              pend_o,
    output logic [VEC_W-1:0]  pend_vec_o
);

    localparam int NUM_WRD = NUM_VEC / WORD_W;
    localparam int WSEL_W  = (NUM_WRD > 1) ? $clog2(NUM_WRD) : 1;

    logic [NUM_VEC-1:0] req_q;
    logic [NUM_VEC-1:0] svc_q;
    logic [NUM_VEC-1:0] en_q;
    logic               req_found;
    logic [VEC_W-1:0]   req_top;
    logic               svc_found;
    logic [VEC_W-1:0]   svc_top;
    logic               en_we;
    logic [WSEL_W-1:0]  en_wsel;
    logic [WORD_W-1:0]  en_wdata;

    ivt_prio_enc #(.WIDTH(NUM_VEC), .IDX_W(VEC_W)) u_req_enc (
        .bits  (req_q),
        .found (req_found),
        .idx   (req_top)
    );

    ivt_prio_enc #(.WIDTH(NUM_VEC), .IDX_W(VEC_W)) u_svc_enc (
        .bits  (svc_q),
        .found (svc_found),
        .idx   (svc_top)
    );

    ivt_vec_state #(
        .NUM_VEC (NUM_VEC),
        .WORD_W  (WORD_W),
        .VEC_W   (VEC_W),
        .NUM_WRD (NUM_WRD),
        .WSEL_W  (WSEL_W)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .raise_vld   (raise_vld),
        .raise_vec   (raise_vec),
        .ack_vld     (ack_vld),
        .ack_vec     (ack_vec),
        .eoi         (eoi),
        .svc_top_vld (svc_found),
        .svc_top_idx (svc_top),
        .en_we       (en_we),
        .en_wsel     (en_wsel),
        .en_wdata    (en_wdata),
        .req_q       (req_q),
        .svc_q       (svc_q),
        .en_q        (en_q)
    );

    ivt_reg_if #(
        .NUM_VEC (NUM_VEC),
        .WORD_W  (WORD_W),
        .ADDR_W  (ADDR_W),
        .NUM_WRD (NUM_WRD),
        .WSEL_W  (WSEL_W)
    ) u_regs (
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .req_q     (req_q),
        .svc_q     (svc_q),
        .en_q      (en_q),
        .en_we     (en_we),
        .en_wsel   (en_wsel),
        .en_wdata  (en_wdata),
        .reg_rdata (reg_rdata)
    );

    logic pend_d;
    // Strict comparison: an idle in-service array acts as level -1
    assign pend_d = req_found && (!svc_found || (req_top > svc_top));

    // Registered pending flag and offered vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o     <= 1'b0;
            pend_vec_o <= '0;
        end else begin
            pend_o     <= pend_d;
            pend_vec_o <= req_found ? req_top : '0;
        end
    end

endmodule

// File: rtl/ivt_checker.sv
// Module ivt_checker
// Concurrent properties for intr_vector_tracker, bound to every instance.
// Assumes single-cycle strobes and eoi that never shares a cycle with ack.
module ivt_checker #(
    parameter int NUM_VEC = 256,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               raise_vld,
    input logic [VEC_W-1:0]   raise_vec,
    input logic               ack_vld,
    input logic [VEC_W-1:0]   ack_vec,
    input logic               eoi,
    input logic               pend_o,
    input logic [NUM_VEC-1:0] req_q,
    input logic [NUM_VEC-1:0] svc_q,
    input logic [NUM_VEC-1:0] en_q
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (req_q == '0 && svc_q == '0 && !pend_o));

    assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && en_q[raise_vec]) |=> req_q[$past(raise_vec)]);

    assert_disabled_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && !en_q[raise_vec] && !req_q[raise_vec]) |=> !req_q[$past(raise_vec)]);

    assert_no_req_no_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q == '0) |=> !pend_o);

    assert_ack_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && req_q[ack_vec]) |=> svc_q[$past(ack_vec)]);

    assert_ack_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && !req_q[ack_vec] && !eoi) |=> (svc_q == $past(svc_q)));

    assert_eoi_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack_vld) |=>
            ($countones(svc_q) + (($past(svc_q) != '0) ? 1 : 0) == $countones($past(svc_q))));

    assert_same_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && ack_vld && raise_vec == ack_vec && req_q[ack_vec] && en_q[raise_vec])
            |=> (req_q[$past(ack_vec)] && svc_q[$past(ack_vec)]));

endmodule

bind intr_vector_tracker ivt_checker #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_vld (raise_vld),
    .raise_vec (raise_vec),
    .ack_vld   (ack_vld),
    .ack_vec   (ack_vec),
    .eoi       (eoi),
    .pend_o    (pend_o),
    .req_q     (req_q),
    .svc_q     (svc_q),
    .en_q      (en_q)
);

// File: tb/intr_vector_tracker_tb_top.sv
`timescale 1ns/1ps
module intr_vector_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        raise_vld;
    logic [7:0]  raise_vec;
    logic        ack_vld;
    logic [7:0]  ack_vec;
    logic        eoi;
    logic [11:0] reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        pend_o;
    logic [7:0]  pend_vec_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    intr_vector_tracker dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_vld  (raise_vld),
        .raise_vec  (raise_vec),
        .ack_vld    (ack_vld),
        .ack_vec    (ack_vec),
        .eoi        (eoi),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pend_o     (pend_o),
        .pend_vec_o (pend_vec_o)
    );

    typedef struct {
        bit          is_pend;
        logic [31:0] expv;
        string       tag;
    } item_t;

    item_t exp_q[$];

    // Monitor: pop one expected item per cycle and compare mid-cycle
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        if (exp_q.size() > 0) begin
            it  = exp_q.pop_front();
            act = it.is_pend ? {23'd0, pend_o, pend_vec_o} : reg_rdata;
            checks++;
            if (act !== it.expv) begin
                errors++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.expv);
            end
        end
    end

    // All tasks start and end one time unit after a rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic raise(input logic [7:0] v);
        raise_vld = 1'b1; raise_vec = v;
        step();
        raise_vld = 1'b0;
    endtask

    task automatic ack(input logic [7:0] v);
        ack_vld = 1'b1; ack_vec = v;
        step();
        ack_vld = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        step();
        eoi = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr   = a;
        it.is_pend = 1'b0; it.expv = e; it.tag = tag;
        exp_q.push_back(it);
        step();
    endtask

    // Waits one cycle so the registered outputs catch up, then checks them
    task automatic expect_pend(input logic p, input logic [7:0] v, input string tag);
        item_t it;
        step();
        it.is_pend = 1'b1; it.expv = {23'd0, p, v}; it.tag = tag;
        exp_q.push_back(it);
        step();
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; raise_vld = 1'b0; raise_vec = '0; ack_vld = 1'b0; ack_vec = '0;
        eoi = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(12'h100, 32'h0,        "R1 in-service word0");
        expect_rd(12'h270, 32'h0,        "R1 request word7");
        expect_rd(12'h4B0, 32'hFFFFFFFF, "R1 enable word3");
        expect_pend(1'b0, 8'h00,         "R1 pend after reset");

        // R2 raise 0x41 -> word 2 bit 1; R6 offered vector
        raise(8'h41);
        expect_rd(12'h220, 32'h00000002, "R2 request word2");
        expect_pend(1'b1, 8'h41,         "R6 pend vector 0x41");

        // R3 / R9 disable vector 255 and raise it
        wr(12'h4F0, 32'h7FFFFFFF);
        expect_rd(12'h4F0, 32'h7FFFFFFF, "R9 enable word7 readback");
        raise(8'hFF);
        expect_rd(12'h270, 32'h0,        "R3 disabled raise dropped");
        expect_pend(1'b1, 8'h41,         "R3 offered vector unchanged");

        // R4 duplicate raise merges; one ack empties it
        raise(8'h41);
        expect_rd(12'h220, 32'h00000002, "R4 merged request");
        ack(8'h41);
        expect_rd(12'h220, 32'h0,        "R4 R7 request cleared by ack");
        expect_rd(12'h120, 32'h00000002, "R7 in-service set by ack");
        expect_pend(1'b0, 8'h00,         "R4 nothing pending after ack");

        // R7 ack of an unrequested vector
        ack(8'h41);
        expect_rd(12'h120, 32'h00000002, "R7 unrequested ack no change");
        ack(8'h05);
        expect_rd(12'h100, 32'h0,        "R7 unrequested ack vector 5");

        // R5 lower, equal, higher request against in-service 0x41
        raise(8'h30);
        expect_pend(1'b0, 8'h30,         "R5 lower request not pending");
        raise(8'h41);
        expect_pend(1'b0, 8'h41,         "R5 equal request not pending");
        raise(8'h90);
        expect_pend(1'b1, 8'h90,         "R5 higher request pending");

        // R8 eoi clears only the highest in-service vector
        ack(8'h90);
        expect_rd(12'h140, 32'h00010000, "R7 in-service 0x90 word4");
        do_eoi();
        expect_rd(12'h140, 32'h0,        "R8 eoi cleared 0x90");
        expect_rd(12'h120, 32'h00000002, "R8 eoi kept 0x41");
        expect_pend(1'b0, 8'h41,         "R5 equal after eoi");
        do_eoi();
        expect_rd(12'h120, 32'h0,        "R8 second eoi cleared 0x41");
        expect_pend(1'b1, 8'h41,         "R5 pending with empty in-service");
        do_eoi();
        expect_rd(12'h120, 32'h0,        "R8 eoi with nothing in service");
        expect_rd(12'h220, 32'h00000002, "R8 eoi left request 0x41");
        expect_rd(12'h210, 32'h00010000, "R8 eoi left request 0x30");

        // R10 raise and ack of the same vector in one cycle
        raise_vld = 1'b1; raise_vec = 8'h41; ack_vld = 1'b1; ack_vec = 8'h41;
        step();
        raise_vld = 1'b0; ack_vld = 1'b0;
        expect_rd(12'h120, 32'h00000002, "R10 in service after same-cycle");
        expect_rd(12'h220, 32'h00000002, "R10 requested again");
        expect_pend(1'b0, 8'h41,         "R10 equal so not pending");

        // R9 writes outside the enable words are ignored
        wr(12'h100, 32'hFFFFFFFF);
        expect_rd(12'h100, 32'h0,        "R9 in-service write ignored");
        wr(12'h200, 32'hFFFFFFFF);
        expect_rd(12'h200, 32'h0,        "R9 request write ignored");
        wr(12'h488, 32'h0);
        expect_rd(12'h480, 32'hFFFFFFFF, "R9 unaligned enable write ignored");
        expect_rd(12'h300, 32'h0,        "R9 unmapped read is zero");

        // R2 R6 top vector after re-enable
        wr(12'h4F0, 32'hFFFFFFFF);
        raise(8'hFF);
        expect_rd(12'h270, 32'h80000000, "R2 request vector 255");
        expect_pend(1'b1, 8'hFF,         "R6 pend vector 0xFF");

        step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule